// File: doc/BRIEF.md
# Integer Operate Unit with Conditional Move

This unit carries out the register-to-register integer operations of a 64-bit processor in one registered stage. Each cycle it takes a 32-bit instruction word and the two values read from the register file for the ra and rb fields. One clock edge later it presents a result, a write strobe, the destination register index and a flag for an unrecognised function code. Two major opcode groups are handled. The arithmetic group covers 32-bit and 64-bit add, subtract, add and subtract with the first operand scaled by 4 or 8, and compares that yield 0 or 1. The logical group covers AND, OR and XOR, each also with the second operand inverted, and eight conditional moves that test the first operand.

Instruction bit 12 selects an 8-bit zero-extended literal in place of the second register operand. Register index 31 reads as zero whatever the register file supplies, and a result aimed at index 31 is never written. Any major opcode outside the two groups is left alone: no write and no flag. The datapath is split into a field decoder, an arithmetic unit and a logical unit. The top selects the group and registers the outputs. The register file, multiply and floating point sit outside this block.

Top module: `intop_unit`

## Requirements
- R1: The major opcode is bits 31:26, ra is bits 25:21, rb is bits 20:16, the function code is bits 11:5 and rc is bits 4:0. Outputs are registered, so `dst_idx` shows rc one cycle after the instruction. After reset all outputs are zero.
- R2: When bit 12 is 1, operand B is bits 20:13 zero-extended to 64 bits, and the rb operand input is ignored.
- R3: An ra index of 31 gives operand A = 0. An rb index of 31 with bit 12 clear gives operand B = 0. In both cases the operand inputs are ignored.
- R4: When rc is 31, `wr_en` is 0 for every instruction.
- R5: In group 0x10, function 0x20 gives A+B and function 0x29 gives A-B, both modulo 2^64.
- R6: In group 0x10, function 0x00 adds the low 32 bits of A and B and sign-extends bit 31 of the sum into bits 63:32.
- R7: In group 0x10, function 0x22 gives 4A+B, 0x2B gives 4A-B, 0x32 gives 8A+B and 0x3B gives 8A-B, all modulo 2^64.
- R8: In group 0x10, the compares give 1 when true and 0 otherwise: 0x2D A==B, 0x1D A<B unsigned, 0x3D A<=B unsigned, 0x4D A<B signed.
- R9: In group 0x11, function 0x00 gives A&B, 0x08 gives A&~B, 0x20 gives A|B, 0x28 gives A|~B, 0x40 gives A^B and 0x48 gives A^~B.
- R10: In group 0x11, the conditional moves result in B. Each writes only when A meets its test: 0x14 A[0]=1, 0x16 A[0]=0, 0x24 A==0, 0x26 A!=0, 0x44 A<0, 0x46 A>=0, 0x64 A<=0, 0x66 A>0 (signed). When the test fails, `wr_en` is 0.
- R11: In groups 0x10 and 0x11, a function code not listed above sets `bad_func` to 1 and `wr_en` to 0.
- R12: A major opcode other than 0x10 or 0x11 gives `wr_en` = 0 and `bad_func` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word |
| opnd_a | input | 64 | Register file value for index ra |
| opnd_b | input | 64 | Register file value for index rb |
| result | output | 64 | Registered result |
| wr_en | output | 1 | Registered write strobe for `dst_idx` |
| dst_idx | output | 5 | Registered destination index (rc) |
| bad_func | output | 1 | Registered unrecognised-function flag |

## Verification
Some properties are checked on every cycle against the instruction of the cycle before. No write ever lands on index 31. A flagged function never writes. A compare result carries nothing above bit 0. A failing zero-test move suppresses the write. A foreign opcode stays silent. A literal added to a zero ra comes out unchanged. Other behaviour can only be shown by the bench's scenarios comparing against its reference model. That covers the exact sums and scaled values, wrap-around at 64 bits, the sign extension of the 32-bit add, and the signed versus unsigned split on negative operands. It also covers every conditional move on both sides of its boundary, and the masking of the operand inputs under index 31 and the literal.

// File: rtl/intop_pkg.sv
`timescale 1ns/1ps
package intop_pkg;
    localparam int OPC_W  = 6;
    localparam int FN_W   = 7;
    localparam int IDX_W  = 5;
    localparam int LIT_W  = 8;

    localparam logic [OPC_W-1:0] GRP_ARITH = 6'h10;
    localparam logic [OPC_W-1:0] GRP_LOGIC = 6'h11;
    localparam logic [IDX_W-1:0] ZERO_IDX  = 5'd31;

    // arithmetic group function codes
    localparam logic [FN_W-1:0] FA_ADD32  = 7'h00;
    localparam logic [FN_W-1:0] FA_CMPULT = 7'h1D;
    localparam logic [FN_W-1:0] FA_ADD    = 7'h20;
    localparam logic [FN_W-1:0] FA_S4ADD  = 7'h22;
    localparam logic [FN_W-1:0] FA_SUB    = 7'h29;
    localparam logic [FN_W-1:0] FA_S4SUB  = 7'h2B;
    localparam logic [FN_W-1:0] FA_CMPEQ  = 7'h2D;
    localparam logic [FN_W-1:0] FA_S8ADD  = 7'h32;
    localparam logic [FN_W-1:0] FA_S8SUB  = 7'h3B;
    localparam logic [FN_W-1:0] FA_CMPULE = 7'h3D;
    localparam logic [FN_W-1:0] FA_CMPLT  = 7'h4D;

    // logical group function codes
    localparam logic [FN_W-1:0] FL_AND    = 7'h00;
    localparam logic [FN_W-1:0] FL_ANDN   = 7'h08;
    localparam logic [FN_W-1:0] FL_MVLBS  = 7'h14;
    localparam logic [FN_W-1:0] FL_MVLBC  = 7'h16;
    localparam logic [FN_W-1:0] FL_OR     = 7'h20;
    localparam logic [FN_W-1:0] FL_MVEQ   = 7'h24;
    localparam logic [FN_W-1:0] FL_MVNE   = 7'h26;
    localparam logic [FN_W-1:0] FL_ORN    = 7'h28;
    localparam logic [FN_W-1:0] FL_XOR    = 7'h40;
    localparam logic [FN_W-1:0] FL_MVLT   = 7'h44;
    localparam logic [FN_W-1:0] FL_MVGE   = 7'h46;
    localparam logic [FN_W-1:0] FL_XORN   = 7'h48;
    localparam logic [FN_W-1:0] FL_MVLE   = 7'h64;
    localparam logic [FN_W-1:0] FL_MVGT   = 7'h66;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_ARITH = 2'd1,
        SEL_LOGIC = 2'd2
    } grp_sel_e;
endpackage

// File: rtl/intop_fields.sv
`timescale 1ns/1ps
module intop_fields
    import intop_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output grp_sel_e          grp,
    output logic [FN_W-1:0]   fn,
    output logic [IDX_W-1:0]  rc,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val
);
    logic [OPC_W-1:0] major;
    logic [IDX_W-1:0] ra, rb;
    logic             use_lit;
    logic [LIT_W-1:0] lit;

    assign major   = instr[31:26];
    assign ra      = instr[25:21];
    assign rb      = instr[20:16];
    assign lit     = instr[20:13];
    assign use_lit = instr[12];
    assign fn      = instr[11:5];
    assign rc      = instr[4:0];

    always_comb begin
        unique case (major)
            GRP_ARITH: grp = SEL_ARITH;
            GRP_LOGIC: grp = SEL_LOGIC;
            default:   grp = SEL_NONE;
        endcase
    end

    always_comb begin
        a_val = (ra == ZERO_IDX) ? '0 : opnd_a;
        if (use_lit)
            b_val = {{(DATA_W-LIT_W){1'b0}}, lit};
        else if (rb == ZERO_IDX)
            b_val = '0;
        else
            b_val = opnd_b;
    end
endmodule

// File: rtl/intop_arith.sv
`timescale 1ns/1ps
module intop_arith
    import intop_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [FN_W-1:0]   fn,
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] b_val,
    output logic [DATA_W-1:0] res,
    output logic              known
);
    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] low_sum;
    logic [DATA_W-1:0] a_x4, a_x8;

    assign low_sum = a_val[HALF_W-1:0] + b_val[HALF_W-1:0];
    assign a_x4    = a_val << 2;
    assign a_x8    = a_val << 3;

    always_comb begin
        res   = '0;
        known = 1'b1;
        unique case (fn)
            FA_ADD32:  res = {{HALF_W{low_sum[HALF_W-1]}}, low_sum};
            FA_ADD:    res = a_val + b_val;
            FA_SUB:    res = a_val - b_val;
            FA_S4ADD:  res = a_x4 + b_val;
            FA_S4SUB:  res = a_x4 - b_val;
            FA_S8ADD:  res = a_x8 + b_val;
            FA_S8SUB:  res = a_x8 - b_val;
            FA_CMPEQ:  res = {{(DATA_W-1){1'b0}}, a_val == b_val};
            FA_CMPULT: res = {{(DATA_W-1){1'b0}}, a_val < b_val};
            FA_CMPULE: res = {{(DATA_W-1){1'b0}}, a_val <= b_val};
            FA_CMPLT:  res = {{(DATA_W-1){1'b0}}, $signed(a_val) < $signed(b_val)};
            default:   known = 1'b0;
        endcase
    end
endmodule

// File: rtl/intop_logic.sv
`timescale 1ns/1ps
module intop_logic
    import intop_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [FN_W-1:0]   fn,
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] b_val,
    output logic [DATA_W-1:0] res,
    output logic              known,
    output logic              take
);
    logic a_zero, a_neg;

    assign a_zero = (a_val == '0);
    assign a_neg  = a_val[DATA_W-1];

    always_comb begin
        res   = b_val;
        known = 1'b1;
        take  = 1'b1;
        unique case (fn)
            FL_AND:   res = a_val & b_val;
            FL_ANDN:  res = a_val & ~b_val;
            FL_OR:    res = a_val | b_val;
            FL_ORN:   res = a_val | ~b_val;
            FL_XOR:   res = a_val ^ b_val;
            FL_XORN:  res = a_val ^ ~b_val;
            FL_MVLBS: take = a_val[0];
            FL_MVLBC: take = ~a_val[0];
            FL_MVEQ:  take = a_zero;
            FL_MVNE:  take = ~a_zero;
            FL_MVLT:  take = a_neg;
            FL_MVGE:  take = ~a_neg;
            FL_MVLE:  take = a_neg | a_zero;
            FL_MVGT:  take = ~a_neg & ~a_zero;
            default: begin
                known = 1'b0;
                take  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/intop_unit.sv
`timescale 1ns/1ps
module intop_unit
    import intop_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic [IDX_W-1:0]  dst_idx,
    output logic              bad_func
);
    grp_sel_e          grp;
    logic [FN_W-1:0]   fn;
    logic [IDX_W-1:0]  rc;
    logic [DATA_W-1:0] a_val, b_val;
    logic [DATA_W-1:0] ar_res, lg_res;
    logic              ar_known, lg_known, lg_take;
    logic [DATA_W-1:0] res_d;
    logic              wr_d, bad_d;

    intop_fields #(.DATA_W(DATA_W)) u_fields (
        .instr(instr), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .grp(grp), .fn(fn), .rc(rc), .a_val(a_val), .b_val(b_val)
    );

    intop_arith #(.DATA_W(DATA_W)) u_arith (
        .fn(fn), .a_val(a_val), .b_val(b_val),
        .res(ar_res), .known(ar_known)
    );

    intop_logic #(.DATA_W(DATA_W)) u_logic (
        .fn(fn), .a_val(a_val), .b_val(b_val),
        .res(lg_res), .known(lg_known), .take(lg_take)
    );

    always_comb begin
        res_d = '0;
        wr_d  = 1'b0;
        bad_d = 1'b0;
        unique case (grp)
            SEL_ARITH: begin
                res_d = ar_res;
                wr_d  = ar_known;
                bad_d = ~ar_known;
            end
            SEL_LOGIC: begin
                res_d = lg_res;
                wr_d  = lg_known & lg_take;
                bad_d = ~lg_known;
            end
            default: ;
        endcase
        if (rc == ZERO_IDX)
            wr_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            wr_en    <= 1'b0;
            dst_idx  <= '0;
            bad_func <= 1'b0;
        end else begin
            result   <= res_d;
            wr_en    <= wr_d;
            dst_idx  <= rc;
            bad_func <= bad_d;
        end
    end

    // ---------------- assertions ----------------
    logic is_cmp;
    assign is_cmp = (instr[31:26] == GRP_ARITH) &&
                    (instr[11:5] == FA_CMPEQ || instr[11:5] == FA_CMPULT ||
                     instr[11:5] == FA_CMPULE || instr[11:5] == FA_CMPLT);

    assert_no_zero_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[4:0] == ZERO_IDX) |=> !wr_en);

    assert_bad_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bad_func |-> !wr_en);

    assert_cmp_boolean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |=> (result[DATA_W-1:1] == '0));

    assert_cmov_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == GRP_LOGIC && instr[11:5] == FL_MVEQ &&
         instr[25:21] != ZERO_IDX && opnd_a != '0) |=> !wr_en);

    assert_foreign_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] != GRP_ARITH && instr[31:26] != GRP_LOGIC) |=> (!wr_en && !bad_func));

    assert_literal_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == GRP_ARITH && instr[11:5] == FA_ADD && instr[12] &&
         instr[25:21] == ZERO_IDX && instr[4:0] != ZERO_IDX)
        |=> (wr_en && result == {{(DATA_W-LIT_W){1'b0}}, $past(instr[20:13])}));
endmodule

// File: tb/intop_unit_test.sv
`timescale 1ns/1ps
module intop_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic [63:0] result;
    logic        wr_en, bad_func;
    logic [4:0]  dst_idx;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    intop_unit uut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .wr_en(wr_en), .dst_idx(dst_idx), .bad_func(bad_func)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] ra,
                                       input logic [4:0] rb, input logic [6:0] fn,
                                       input logic [4:0] rc);
        return {op, ra, rb, 4'b0000, fn, rc};
    endfunction

    function automatic logic [31:0] mkl(input logic [5:0] op, input logic [4:0] ra,
                                        input logic [7:0] lit, input logic [6:0] fn,
                                        input logic [4:0] rc);
        return {op, ra, lit, 1'b1, fn, rc};
    endfunction

    function automatic void model(input logic [31:0] ins, input logic [63:0] ra_v,
                                  input logic [63:0] rb_v, output logic [63:0] r,
                                  output logic we, output logic bad);
        logic [63:0] a, b;
        logic [31:0] s;
        logic ok;
        a = (ins[25:21] == 5'd31) ? 64'd0 : ra_v;
        if (ins[12]) b = {56'd0, ins[20:13]};
        else b = (ins[20:16] == 5'd31) ? 64'd0 : rb_v;
        r = 64'd0; we = 1'b1; ok = 1'b1;
        if (ins[31:26] == 6'h10) begin
            case (ins[11:5])
                7'h00: begin s = a[31:0] + b[31:0]; r = {{32{s[31]}}, s}; end
                7'h20: r = a + b;
                7'h29: r = a - b;
                7'h22: r = a * 4 + b;
                7'h2B: r = a * 4 - b;
                7'h32: r = a * 8 + b;
                7'h3B: r = a * 8 - b;
                7'h2D: r = {63'd0, a == b};
                7'h1D: r = {63'd0, a < b};
                7'h3D: r = {63'd0, a <= b};
                7'h4D: r = {63'd0, $signed(a) < $signed(b)};
                default: ok = 1'b0;
            endcase
        end else if (ins[31:26] == 6'h11) begin
            r = b;
            case (ins[11:5])
                7'h00: r = a & b;
                7'h08: r = a & ~b;
                7'h20: r = a | b;
                7'h28: r = a | ~b;
                7'h40: r = a ^ b;
                7'h48: r = ~(a ^ b);
                7'h14: we = a[0];
                7'h16: we = !a[0];
                7'h24: we = (a == 0);
                7'h26: we = (a != 0);
                7'h44: we = ($signed(a) < 0);
                7'h46: we = ($signed(a) >= 0);
                7'h64: we = ($signed(a) <= 0);
                7'h66: we = ($signed(a) > 0);
                default: ok = 1'b0;
            endcase
        end else begin
            we = 1'b0; bad = 1'b0;
            return;
        end
        bad = !ok;
        if (!ok || ins[4:0] == 5'd31) we = 1'b0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [31:0] ins,
                         input logic [63:0] a, input logic [63:0] b);
        logic [63:0] er;
        logic ew, eb;
        instr = ins; opnd_a = a; opnd_b = b;
        model(ins, a, b, er, ew, eb);
        @(negedge clk);
        chk({tag, " R1 dst"}, {59'd0, dst_idx}, {59'd0, ins[4:0]});
        chk({tag, " wr_en"}, {63'd0, wr_en}, {63'd0, ew});
        chk({tag, " bad_func"}, {63'd0, bad_func}, {63'd0, eb});
        if (ew) chk({tag, " result"}, result, er);
    endtask

    localparam logic [6:0] ARF [11] = '{7'h00, 7'h20, 7'h29, 7'h22, 7'h2B, 7'h32,
                                        7'h3B, 7'h2D, 7'h1D, 7'h3D, 7'h4D};
    localparam logic [6:0] LGF [14] = '{7'h00, 7'h08, 7'h20, 7'h28, 7'h40, 7'h48, 7'h14,
                                        7'h16, 7'h24, 7'h26, 7'h44, 7'h46, 7'h64, 7'h66};

    initial begin
        #1000000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1234);
        instr = mk(6'h10, 5'd1, 5'd2, 7'h20, 5'd3);
        opnd_a = 64'h1234; opnd_b = 64'h1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset result", result, 64'd0);
        chk("R1 reset wr_en", {63'd0, wr_en}, 64'd0);
        chk("R1 reset dst", {59'd0, dst_idx}, 64'd0);
        chk("R1 reset bad", {63'd0, bad_func}, 64'd0);
        rst_n = 1'b1;

        apply("R5 add wrap", mk(6'h10, 5'd1, 5'd2, 7'h20, 5'd3), 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
        apply("R5 sub", mk(6'h10, 5'd1, 5'd2, 7'h29, 5'd4), 64'd5, 64'd9);
        apply("R6 add32 sign", mk(6'h10, 5'd1, 5'd2, 7'h00, 5'd5), 64'hAAAA_0000_7FFF_FFFF, 64'd1);
        apply("R6 add32 pos", mk(6'h10, 5'd1, 5'd2, 7'h00, 5'd5), 64'hFFFF_FFFF_0000_0010, 64'h5_0000_0001);
        apply("R7 s4sub", mk(6'h10, 5'd1, 5'd2, 7'h2B, 5'd6), 64'd3, 64'd20);
        apply("R7 s8add", mk(6'h10, 5'd1, 5'd2, 7'h32, 5'd6), 64'h2000_0000_0000_0001, 64'd7);
        apply("R8 ult neg", mk(6'h10, 5'd1, 5'd2, 7'h1D, 5'd7), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        apply("R8 slt neg", mk(6'h10, 5'd1, 5'd2, 7'h4D, 5'd7), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        apply("R8 ule eq", mk(6'h10, 5'd1, 5'd2, 7'h3D, 5'd7), 64'd9, 64'd9);
        apply("R2 literal", mkl(6'h10, 5'd31, 8'hFF, 7'h20, 5'd8), 64'h55, 64'h99);
        apply("R2 literal add", mkl(6'h10, 5'd1, 8'h80, 7'h20, 5'd8), 64'h100, 64'hDEAD);
        apply("R3 ra zero", mk(6'h10, 5'd31, 5'd2, 7'h20, 5'd9), 64'h1111, 64'h22);
        apply("R3 rb zero", mk(6'h11, 5'd1, 5'd31, 7'h20, 5'd9), 64'h33, 64'h4444);
        apply("R4 rc31", mk(6'h10, 5'd1, 5'd2, 7'h20, 5'd31), 64'd1, 64'd2);
        apply("R4 rc31 cmov", mk(6'h11, 5'd1, 5'd2, 7'h26, 5'd31), 64'd1, 64'd2);
        apply("R9 orn", mk(6'h11, 5'd1, 5'd2, 7'h28, 5'd10), 64'h0F, 64'hF0);
        apply("R9 xorn", mk(6'h11, 5'd1, 5'd2, 7'h48, 5'd10), 64'h0F, 64'hF0);
        apply("R10 gt zero", mk(6'h11, 5'd1, 5'd2, 7'h66, 5'd11), 64'd0, 64'd77);
        apply("R10 gt pos", mk(6'h11, 5'd1, 5'd2, 7'h66, 5'd11), 64'd1, 64'd77);
        apply("R10 le zero", mk(6'h11, 5'd1, 5'd2, 7'h64, 5'd11), 64'd0, 64'd78);
        apply("R10 lt neg", mk(6'h11, 5'd1, 5'd2, 7'h44, 5'd11), 64'h8000_0000_0000_0000, 64'd79);
        apply("R10 eq fail", mk(6'h11, 5'd1, 5'd2, 7'h24, 5'd11), 64'd4, 64'd80);
        apply("R10 lbc", mk(6'h11, 5'd1, 5'd2, 7'h16, 5'd11), 64'd4, 64'd81);
        apply("R11 arith bad", mk(6'h10, 5'd1, 5'd2, 7'h01, 5'd12), 64'd1, 64'd1);
        apply("R11 logic bad", mk(6'h11, 5'd1, 5'd2, 7'h7F, 5'd12), 64'd1, 64'd1);
        apply("R12 foreign", mk(6'h12, 5'd1, 5'd2, 7'h20, 5'd12), 64'd1, 64'd1);

        for (int i = 0; i < 1500; i++) begin
            logic [31:0] ins;
            logic [63:0] a, b;
            logic [6:0] f;
            int k;
            k = $urandom_range(0, 9);
            if (k < 4) f = ARF[$urandom_range(0, 10)];
            else if (k < 8) f = LGF[$urandom_range(0, 13)];
            else f = 7'($urandom);
            ins = $urandom;
            ins[11:5] = f;
            ins[31:26] = (k == 9) ? 6'($urandom) : ((k < 4 || k == 8) ? 6'h10 : 6'h11);
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) a = 64'($urandom_range(0, 2)) - 64'd1;
            apply("R5-R11 random", ins, a, b);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule